// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short global record of the directions of the most recent resolved branches. That record, combined with a few low-order bits of the branch address, selects one saturating counter from a table. A branch therefore gets a separate counter for each recent-outcome pattern, which lets it follow the behaviour of neighbouring branches.

On the fetch side, a PC enters and a taken/not-taken guess leaves in the same cycle. The current history is returned with the guess so that the pipeline can carry it with the branch. On the resolve side, the branch PC, its real direction and that saved history are presented. At the next clock edge the counter that made the guess moves one step toward the real direction, and the real direction is shifted into the history.

The parameters are the history length, the counter width and the number of PC index bits. With no history and one-bit counters, the block becomes a table that records the last outcome of each branch.

Top module: `bp_corr_predictor`

## Requirements
- R1: After synchronous active-low reset, the history is all zeros and every counter holds the weakly not-taken value 2^(n-1)-1. Every prediction is therefore not-taken.
- R2: `fetch_taken` is combinational in the same cycle. It is the MSB of the counter at table index {history, fetch_pc[k+1:2]}, with the history in the upper bits.
- R3: `fetch_hist` shows the current global history register in the same cycle.
- R4: When `res_valid` is high, the counter at {res_hist, res_pc[k+1:2]} moves up by one if `res_taken` is 1 and down by one if it is 0. The snapshot `res_hist` selects the counter, not the current history. No other counter changes.
- R5: Counters saturate. A taken update at 2^n-1 and a not-taken update at 0 leave the counter unchanged.
- R6: With 2-bit counters, a strongly predicted direction needs two consecutive opposite outcomes before the prediction flips.
- R7: When `res_valid` is high, the history shifts left by one bit and `res_taken` enters bit 0, so the oldest outcome drops out. Without `res_valid` the history holds its value.
- R8: No tag is kept. PCs that differ only in bits [1:0] or above bit k+1 share a counter.
- R9: Under different history values, the same PC selects different counters.
- R10: With zero history bits and 1-bit counters, the prediction for a PC is its last resolved direction, and it inverts after a single misprediction. In that configuration `fetch_hist` reads 0.
- R11: A prediction made in the same cycle as a resolve to the same counter sees the value before the update. The updated value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| fetch_taken | output | 1 | Predicted direction, 1 = taken |
| fetch_hist | output | max(HIST_BITS,1) | History used for this prediction, to be saved with the branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real direction of the resolving branch |
| res_hist | input | max(HIST_BITS,1) | History snapshot taken when that branch was predicted |

## Verification
`fetch_taken` and `fetch_hist` are combinational and are due in the same cycle as `fetch_pc`. A resolve takes effect on counters and history at the following rising edge, so its effect is visible one cycle later. The bench changes inputs on the falling edge and samples 1 ns later, before the rising edge. Each prediction is therefore compared with a behavioural model whose state has not yet taken the current cycle's resolve. The model is updated only after that rising edge. Directed sequences count out the expected counter values for hysteresis, aliasing, history separation and same-cycle read-before-write. A second instance with no history and 1-bit counters runs on the same stimulus.

// File: rtl/bp_pkg.sv
// Shared constants and helpers for the correlating branch predictor.
// Assumes instructions are 4-byte aligned, so PC bits [1:0] carry no index information.
package bp_pkg;
    localparam int PC_LSB = 2;

    // Weakly not-taken counter value for a counter of the given width.
    function automatic int weak_not_taken(input int ctr_bits);
        return (1 << (ctr_bits - 1)) - 1;
    endfunction
endpackage

// File: rtl/bp_index_gen.sv
// Builds a table index from the PC index bits and the global history.
// The history sits above the PC bits. With HIST_BITS == 0 only the PC bits are used.
module bp_index_gen #(
    parameter int HIST_BITS   = 2,
    parameter int PC_IDX_BITS = 4,
    parameter int HW          = (HIST_BITS > 0) ? HIST_BITS : 1,
    parameter int IDX_W       = HIST_BITS + PC_IDX_BITS
) (
    input  logic [PC_IDX_BITS-1:0] pc_bits,
    input  logic [HW-1:0]          hist,
    output logic [IDX_W-1:0]       idx
);
    generate
        if (HIST_BITS > 0) begin : g_corr
            // Concatenate the history above the PC index.
            assign idx = {hist[HIST_BITS-1:0], pc_bits};
        end else begin : g_plain
            // No history: the index is the PC bits alone.
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = pc_bits;
        end
    endgenerate
endmodule

// File: rtl/bp_hist_reg.sv
// Global outcome history shift register. A resolved direction enters bit 0.
// Assumes at most one resolve per cycle. Resets to all zeros.
module bp_hist_reg #(
    parameter int HIST_BITS = 2,
    parameter int HW        = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist_q
);
    generate
        if (HIST_BITS == 0) begin : g_none
            // Without history the output is tied to zero.
            logic unused_in;
            assign unused_in = shift_en ^ bit_in ^ clk ^ rst_n;
            assign hist_q = '0;
        end else begin : g_shift
            logic [HIST_BITS-1:0] q;
            // Shift in the resolved direction; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (shift_en)
                    q <= (HIST_BITS == 1) ? HIST_BITS'(bit_in)
                                          : HIST_BITS'({q, bit_in});
            end
            assign hist_q = q;

            assert_hist_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> hist_q == '0);
            assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[0] == $past(bit_in));
            assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> hist_q == $past(hist_q));
        end
        if (HIST_BITS > 1) begin : g_upper
            assert_shift_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[HIST_BITS-1:1] == $past(hist_q[HIST_BITS-2:0]));
        end
    endgenerate
endmodule

// File: rtl/bp_sat_step.sv
// Moves a saturating counter one step toward the given direction.
// Purely combinational. Holds the value at either bound.
module bp_sat_step #(
    parameter int CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                taken,
    output logic [CTR_BITS-1:0] nxt
);
    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;

    // Increment toward taken or decrement toward not-taken, clamped at the bounds.
    always_comb begin
        nxt = cur;
        if (taken && cur != CTR_MAX)
            nxt = cur + 1'b1;
        else if (!taken && cur != '0)
            nxt = cur - 1'b1;
    end
endmodule

// File: rtl/bp_ctr_table.sv
// Table of saturating counters with one combinational read port and one write port.
// The write applies at the clock edge, so a read in the same cycle sees the old value.
// Assumes the table is small enough to reset every entry in one cycle.
module bp_ctr_table #(
    parameter int IDX_W    = 6,
    parameter int CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CTR_BITS-1:0] RST_VAL = CTR_BITS'(bp_pkg::weak_not_taken(CTR_BITS));
    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;

    logic [CTR_BITS-1:0] mem [ENTRIES];
    logic [CTR_BITS-1:0] cur;
    logic [CTR_BITS-1:0] nxt;

    // Current value of the entry being updated.
    assign cur = mem[wr_idx];

    bp_sat_step #(.CTR_BITS(CTR_BITS)) u_step (
        .cur   (cur),
        .taken (wr_taken),
        .nxt   (nxt)
    );

    // Reset every entry to weakly not-taken, else write the stepped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                mem[i] <= RST_VAL;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt;
        end
    end

    // Read port for prediction.
    assign rd_ctr = mem[rd_idx];

    assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && cur == CTR_MAX |=> mem[$past(wr_idx)] == CTR_MAX);
    assert_sat_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && cur == '0 |=> mem[$past(wr_idx)] == '0);
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && cur != CTR_MAX |=>
            mem[$past(wr_idx)] == CTR_BITS'($past(cur) + 1'b1));
    assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && cur != '0 |=>
            mem[$past(wr_idx)] == CTR_BITS'($past(cur) - 1'b1));
    assert_no_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem[$past(rd_idx)] == $past(rd_ctr));
endmodule

// File: rtl/bp_corr_predictor.sv
// Correlating two-level branch direction predictor (top).
// Fetch side: a combinational prediction from {history, PC index}.
// Resolve side: updates the counter chosen by the saved history and shifts the history.
// Assumes at most one resolve per cycle and that resolves arrive in program order.
module bp_corr_predictor #(
    parameter int PC_W        = 32,
    parameter int HIST_BITS   = 2,
    parameter int CTR_BITS    = 2,
    parameter int PC_IDX_BITS = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [PC_W-1:0]                            fetch_pc,
    output logic                                       fetch_taken,
    output logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] fetch_hist,
    input  logic                                       res_valid,
    input  logic [PC_W-1:0]                            res_pc,
    input  logic                                       res_taken,
    input  logic [((HIST_BITS > 0) ? HIST_BITS : 1)-1:0] res_hist
);
    localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1;
    localparam int IDX_W = HIST_BITS + PC_IDX_BITS;
    localparam int LSB   = bp_pkg::PC_LSB;
    localparam int MSB   = PC_IDX_BITS + LSB - 1;

    logic [HW-1:0]       ghr;
    logic [IDX_W-1:0]    fetch_idx;
    logic [IDX_W-1:0]    res_idx;
    logic [CTR_BITS-1:0] fetch_ctr;

    // PC bits that never reach the index.
    logic unused_pc;
    assign unused_pc = ^{fetch_pc[PC_W-1:MSB+1], fetch_pc[LSB-1:0],
                         res_pc[PC_W-1:MSB+1],   res_pc[LSB-1:0]};

    bp_hist_reg #(.HIST_BITS(HIST_BITS), .HW(HW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist_q   (ghr)
    );

    bp_index_gen #(.HIST_BITS(HIST_BITS), .PC_IDX_BITS(PC_IDX_BITS), .HW(HW), .IDX_W(IDX_W)) u_fidx (
        .pc_bits (fetch_pc[MSB:LSB]),
        .hist    (ghr),
        .idx     (fetch_idx)
    );

    bp_index_gen #(.HIST_BITS(HIST_BITS), .PC_IDX_BITS(PC_IDX_BITS), .HW(HW), .IDX_W(IDX_W)) u_ridx (
        .pc_bits (res_pc[MSB:LSB]),
        .hist    (res_hist),
        .idx     (res_idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_idx),
        .rd_ctr   (fetch_ctr),
        .wr_en    (res_valid),
        .wr_idx   (res_idx),
        .wr_taken (res_taken)
    );

    // The prediction is the counter's MSB; the history goes out with it.
    assign fetch_taken = fetch_ctr[CTR_BITS-1];
    assign fetch_hist  = ghr;
endmodule

// File: tb/sim_bp_corr_predictor.sv
// Bench: a default (2,2) instance u0 and a last-outcome instance u1 (m=0, n=1) share
// one stimulus. Both are compared every cycle against behavioural models.
module sim_bp_corr_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [1:0]  res_hist = '0;
    logic        pred0, pred1;
    logic [1:0]  hist0;
    logic        hist1;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int m0 [64];
    int m1 [16];
    int g0 = 0;
    int last0 = 0;
    int last1 = 0;

    always #2 clk = ~clk;

    bp_corr_predictor #(.PC_W(32), .HIST_BITS(2), .CTR_BITS(2), .PC_IDX_BITS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(pred0), .fetch_hist(hist0),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .res_hist(res_hist));

    bp_corr_predictor #(.PC_W(32), .HIST_BITS(0), .CTR_BITS(1), .PC_IDX_BITS(4)) u1 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(pred1), .fetch_hist(hist1),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .res_hist(1'b0));

    function automatic int ix0(input logic [31:0] pc, input int h);
        return (h << 4) | int'((pc >> 2) & 32'hF);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, sample before the rising edge, update models after it.
    task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                        input bit rt, input int rh, input string tag);
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_hist = 2'(rh);
        #1;
        last0 = int'(pred0);
        last1 = int'(pred1);
        chk(last0, m0[ix0(fpc, g0)] >> 1, {tag, " R2 u0 prediction"});
        chk(int'(hist0), g0, {tag, " R3 u0 history"});
        chk(last1, m1[(fpc >> 2) & 32'hF], {tag, " R10 u1 prediction"});
        chk(int'(hist1), 0, {tag, " R10 u1 history"});
        @(posedge clk);
        if (rv) begin
            int i = ix0(rpc, rh & 3);
            int j = int'((rpc >> 2) & 32'hF);
            if (rt) begin if (m0[i] < 3) m0[i]++; end
            else    begin if (m0[i] > 0) m0[i]--; end
            m1[j] = rt ? 1 : 0;
            g0 = ((g0 << 1) | int'(rt)) & 3;
        end
    endtask

    localparam logic [31:0] P = 32'h200;
    localparam logic [31:0] Q = 32'h134;

    initial begin
        for (int i = 0; i < 64; i++) m0[i] = 1;
        for (int i = 0; i < 16; i++) m1[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state over a sweep of PCs
        for (int k = 0; k < 16; k++) begin
            step(32'(k * 4), 0, 0, 0, 0, "R1");
            chk(last0, 0, "R1 reset predicts not-taken");
        end
        // Train: ghr 0 -> 1 -> 3, then {3,P} 1 -> 2 -> 3 -> 3 (R5 saturation)
        step(Q, 1, Q, 1, 0, "R4");
        step(Q, 1, Q, 1, 1, "R4");
        repeat (3) step(P, 1, P, 1, 3, "R5");
        step(P, 0, 0, 0, 0, "R2");
        chk(last0, 1, "R2 trained entry predicts taken");
        // R8: aliasing PCs
        step(P + 32'h40, 0, 0, 0, 0, "R8");
        chk(last0, 1, "R8 alias above index bits");
        step(P + 32'h3, 0, 0, 0, 0, "R8");
        chk(last0, 1, "R8 alias in byte offset");
        step(P + 32'h4, 0, 0, 0, 0, "R8");
        chk(last0, 0, "R8 neighbour index untouched");
        // R9: history 0 selects a different counter for P
        step(Q, 1, Q, 0, 1, "R9");
        step(Q, 1, Q, 0, 1, "R9");
        step(P, 0, 0, 0, 0, "R9");
        chk(int'(hist0), 0, "R9 history back to zero");
        chk(last0, 0, "R9 other history pattern untrained");
        // R6: hysteresis on {3,P}
        step(Q, 1, Q, 1, 2, "R7");
        step(Q, 1, Q, 1, 2, "R7");
        step(Q, 1, P, 0, 3, "R6");
        step(Q, 1, Q, 1, 2, "R7");
        step(Q, 1, Q, 1, 2, "R7");
        step(P, 0, 0, 0, 0, "R6");
        chk(last0, 1, "R6 one miss keeps taken");
        step(Q, 1, P, 0, 3, "R6");
        step(Q, 1, Q, 1, 2, "R7");
        step(Q, 1, Q, 1, 2, "R7");
        step(P, 0, 0, 0, 0, "R6");
        chk(last0, 0, "R6 second miss flips");
        chk(last1, 0, "R10 last outcome of P was not-taken");
        // R11: same-cycle resolve and fetch of the same counter
        step(P, 1, P, 1, 3, "R11");
        chk(last0, 0, "R11 pre-update value seen");
        step(P, 0, 0, 0, 0, "R11");
        chk(last0, 1, "R11 update visible next cycle");
        chk(last1, 1, "R10 single taken flips bit");
        step(P, 1, P, 0, 3, "R10");
        step(P, 0, 0, 0, 0, "R10");
        chk(last1, 0, "R10 single miss inverts");
        // Mixed stream, stale and current snapshots (R4, R5, R7, R11)
        begin
            int unsigned s = 32'h1234_5678;
            for (int n = 0; n < 3000; n++) begin
                logic [31:0] fp, rp;
                bit v, t;
                int h;
                s = s * 1664525 + 1013904223;
                fp = {22'(s >> 10), 8'(s >> 4), 2'(s)};
                rp = s[20] ? fp : {24'h0, s[29:22], 2'b0};
                v = s[31] | s[30];
                t = s[27] ^ s[9];
                h = s[15] ? g0 : int'(s[17:16]);
                step(fp, v, rp, t, h, "R4/R7 stream");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule